// File: doc/BRIEF.md
# Quasi-Cyclic Syndrome Unit with All-Zero Detect

This block computes the syndrome of a received word of 2R bits against a parity-check matrix made of two circulant blocks. Each block is given only by its first-row polynomial, `h0` for the low half of the word and `h1` for the high half. After a start pulse, the unit walks both halves together, one bit position per clock cycle. It rotates its copies of `h0` and `h1` one step each cycle. When the current bit of a half is set, the unit XORs the matching rotated polynomial into an R-bit syndrome register.

Once all R positions have been visited, a pipelined OR-reduction tree tests whether the syndrome is all zero. The first level of the tree takes groups of six inputs. A register stage follows the second level, and every later level is registered as well. The unit raises `done` for one cycle only after this pipeline has drained. `done` arrives together with a valid `is_zero` flag. The syndrome and the flag stay on the outputs until the next start.

The secret polynomials are sparse; the intended setting has 45 set bits in each. The datapath does not depend on that weight. It is a building block of a bit-flipping decoder, and the rotation matches the encoder's, so a codeword produces a zero syndrome.

Top module: `qc_syndrome_unit`

## Requirements
- R1: After reset, `busy`, `done` and `is_zero` are 0 and `syndrome` is all zero.
- R2: A `start` seen while idle captures `word_in`, `h0_in` and `h1_in` and raises `busy` from the next cycle. `done` rises R+LAT+1 clock edges after the start edge, and `busy` is low in that cycle. LAT is the number of registered OR-tree levels: (levels − 1) when the tree has two or more levels, otherwise 1. The tree reduces by 6 per level, so with R = 96 the widths are 96, 16, 3, 1, giving LAT = 2.
- R3: The final `syndrome` equals h0·c0 ⊕ h1·c1 in GF(2)[x]/(x^R − 1). Here c0 = `word_in[R-1:0]` and c1 = `word_in[2R-1:R]`. Bit k of every vector is the coefficient of x^k.
- R4: When bit j is set in both halves, the contributions of `h0` and `h1` for that position both enter the syndrome in the same step. Equal contributions therefore cancel.
- R5: In the cycle `done` is high, `is_zero` is 1 exactly when `syndrome` is all zero.
- R6: A word with c0 = h1·m and c1 = h0·m, for any m, yields an all-zero syndrome and `is_zero` = 1.
- R7: `start` pulses and changes on `word_in`, `h0_in` or `h1_in` while `busy` is high have no effect on the result or on the timing of `done`.
- R8: After `done`, `syndrome` and `is_zero` hold their values until the next accepted start.
- R9: `done` is a single-cycle pulse, one per accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a syndrome computation when idle |
| word_in | input | 2R | Received word; low half c0, high half c1 |
| h0_in | input | R | First-row polynomial of the first circulant block |
| h1_in | input | R | First-row polynomial of the second circulant block |
| busy | output | 1 | Computation or tree drain in progress |
| done | output | 1 | One-cycle pulse: result valid |
| syndrome | output | R | Accumulated syndrome |
| is_zero | output | 1 | Syndrome is all zero, valid with done |

## Verification
The two accumulations, h0 selected by the low half and h1 selected by the high half, can fall in the same step. The bench provokes this by setting the same bit position in both halves. In one case the two rotated polynomials differ, and the syndrome must be their XOR. In another, h0 equals h1 and the two halves are identical, so every step's pair of contributions must cancel to a zero syndrome with `is_zero` raised. A scoreboard compares each `done` against an independent polynomial product modulo x^R − 1, and it also checks the latency of `done`.

// File: rtl/qcs_pkg.sv
package qcs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_FIN   = 2'd3
    } qcs_state_e;

    typedef struct packed {
        logic load;   // capture operands, clear syndrome
        logic step;   // accumulate one bit position
        logic fin;    // tree output valid, publish result
    } qcs_ctl_t;

    function automatic int ceil_div(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    // width of OR-tree level lvl (level 0 is the input vector)
    function automatic int tree_width(input int w, input int fan, input int lvl);
        int x;
        x = w;
        for (int i = 0; i < lvl; i++) x = ceil_div(x, fan);
        return x;
    endfunction

    function automatic int tree_levels(input int w, input int fan);
        int x;
        int n;
        x = w;
        n = 0;
        do begin
            x = ceil_div(x, fan);
            n++;
        end while (x > 1);
        return n;
    endfunction

    // registered levels: level 2 and above, or the single level of a tiny tree
    function automatic int tree_latency(input int w, input int fan);
        int n;
        n = tree_levels(w, fan);
        return (n >= 2) ? n - 1 : 1;
    endfunction

endpackage

// File: rtl/qcs_rot_acc.sv
module qcs_rot_acc #(
    parameter int R = 96
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic           step,
    input  logic [2*R-1:0] word_in,
    input  logic [R-1:0]   h0_in,
    input  logic [R-1:0]   h1_in,
    output logic [R-1:0]   syn
);
    logic [R-1:0] c0_sr, c1_sr;
    logic [R-1:0] h0_rot, h1_rot;
    logic [R-1:0] add0, add1;

    // contributions of the two blocks for the current position
    assign add0 = c0_sr[0] ? h0_rot : '0;
    assign add1 = c1_sr[0] ? h1_rot : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            c0_sr  <= '0;
            c1_sr  <= '0;
            h0_rot <= '0;
            h1_rot <= '0;
            syn    <= '0;
        end else if (load) begin
            c0_sr  <= word_in[R-1:0];
            c1_sr  <= word_in[2*R-1:R];
            h0_rot <= h0_in;
            h1_rot <= h1_in;
            syn    <= '0;
        end else if (step) begin
            syn    <= syn ^ add0 ^ add1;
            c0_sr  <= {1'b0, c0_sr[R-1:1]};
            c1_sr  <= {1'b0, c1_sr[R-1:1]};
            // multiply by x: coefficient k moves to k+1
            h0_rot <= {h0_rot[R-2:0], h0_rot[R-1]};
            h1_rot <= {h1_rot[R-2:0], h1_rot[R-1]};
        end
    end
endmodule

// File: rtl/qcs_or_tree.sv
module qcs_or_tree
    import qcs_pkg::*;
#(
    parameter int W   = 96,
    parameter int FAN = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] vec,
    output logic         any
);
    localparam int L = tree_levels(W, FAN);

    for (genvar l = 0; l <= L; l++) begin : g_lvl
        localparam int WL = tree_width(W, FAN, l);
        logic [WL-1:0] bits;
        if (l == 0) begin : g_in
            assign bits = vec;
        end else begin : g_red
            localparam int WP = tree_width(W, FAN, l - 1);
            logic [WL-1:0] red;
            for (genvar g = 0; g < WL; g++) begin : g_grp
                localparam int LO = g * FAN;
                localparam int HI = (LO + FAN - 1 < WP - 1) ? LO + FAN - 1 : WP - 1;
                assign red[g] = |g_lvl[l-1].bits[HI:LO];
            end
            if (l >= 2 || l == L) begin : g_reg
                always_ff @(posedge clk) begin
                    if (rst) bits <= '0;
                    else     bits <= red;
                end
            end else begin : g_comb
                assign bits = red;
            end
        end
    end

    assign any = g_lvl[L].bits[0];
endmodule

// File: rtl/qcs_ctrl.sv
module qcs_ctrl
    import qcs_pkg::*;
#(
    parameter int R   = 96,
    parameter int LAT = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    output qcs_ctl_t ctl,
    output logic     busy,
    output logic     done_q
);
    localparam int IDX_W = (R > 1) ? $clog2(R) : 1;
    localparam int CNT_W = $clog2(LAT + 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(R - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAT - 1);

    qcs_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        ctl.load = (state == ST_IDLE) && start;
        ctl.step = (state == ST_RUN);
        ctl.fin  = (state == ST_FIN);
    end

    assign busy = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            cnt    <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= ctl.fin;
            unique case (state)
                ST_IDLE: if (start) begin
                    state <= ST_RUN;
                    idx   <= '0;
                end
                ST_RUN: begin
                    idx <= idx + 1'b1;
                    if (idx == IDX_LAST) begin
                        state <= ST_DRAIN;
                        cnt   <= '0;
                    end
                end
                ST_DRAIN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_LAST) state <= ST_FIN;
                end
                ST_FIN: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/qc_syndrome_unit.sv
module qc_syndrome_unit
    import qcs_pkg::*;
#(
    parameter int R   = 96,
    parameter int FAN = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [2*R-1:0] word_in,
    input  logic [R-1:0]   h0_in,
    input  logic [R-1:0]   h1_in,
    output logic           busy,
    output logic           done,
    output logic [R-1:0]   syndrome,
    output logic           is_zero
);
    localparam int LAT = tree_latency(R, FAN);

    qcs_ctl_t ctl;
    logic     any_set;

    qcs_ctrl #(.R(R), .LAT(LAT)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .ctl    (ctl),
        .busy   (busy),
        .done_q (done)
    );

    qcs_rot_acc #(.R(R)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .load    (ctl.load),
        .step    (ctl.step),
        .word_in (word_in),
        .h0_in   (h0_in),
        .h1_in   (h1_in),
        .syn     (syndrome)
    );

    qcs_or_tree #(.W(R), .FAN(FAN)) u_tree (
        .clk (clk),
        .rst (rst),
        .vec (syndrome),
        .any (any_set)
    );

    always_ff @(posedge clk) begin
        if (rst)           is_zero <= 1'b0;
        else if (ctl.load) is_zero <= 1'b0;
        else if (ctl.fin)  is_zero <= ~any_set;
    end
endmodule

// File: rtl/qcs_chk.sv
module qcs_chk #(
    parameter int R = 96
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [R-1:0] syndrome,
    input logic         is_zero
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);                                         // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);                                         // R2

    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));                           // R2

    AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (rst)
        done |-> (is_zero == (syndrome == '0)));                 // R5

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!busy && $past(!busy) && !$past(start)) |-> ($stable(syndrome) && $stable(is_zero))); // R8
endmodule

bind qc_syndrome_unit qcs_chk #(.R(R)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .busy     (busy),
    .done     (done),
    .syndrome (syndrome),
    .is_zero  (is_zero)
);

// File: tb/tb_qc_syndrome_unit.sv
`timescale 1ns/1ps
module tb_qc_syndrome_unit;
    localparam int R = 96;

    typedef struct packed {
        logic [R-1:0] syn;
        logic         zero;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           start = 1'b0;
    logic [2*R-1:0] word_in = '0;
    logic [R-1:0]   h0_in = '0;
    logic [R-1:0]   h1_in = '0;
    logic           busy, done, is_zero;
    logic [R-1:0]   syndrome;

    int   n_tests = 0;
    int   n_fail  = 0;
    exp_t sb_q[$];
    int   exp_lat;

    always #10 clk = ~clk;

    qc_syndrome_unit #(.R(R)) dut (
        .clk(clk), .rst(rst), .start(start), .word_in(word_in),
        .h0_in(h0_in), .h1_in(h1_in), .busy(busy), .done(done),
        .syndrome(syndrome), .is_zero(is_zero)
    );

    function automatic logic [R-1:0] pmul(input logic [R-1:0] a, input logic [R-1:0] b);
        logic [R-1:0] r;
        r = '0;
        for (int i = 0; i < R; i++)
            for (int j = 0; j < R; j++)
                if (a[i] && b[j]) r[(i + j) % R] = ~r[(i + j) % R];
        return r;
    endfunction

    function automatic logic [R-1:0] sparse(input int wt);
        logic [R-1:0] v;
        v = '0;
        for (int k = 0; k < wt; k++) v[$urandom_range(R-1, 0)] = 1'b1;
        return v;
    endfunction

    function automatic logic [R-1:0] dense();
        logic [R-1:0] v;
        for (int k = 0; k < R; k++) v[k] = $urandom_range(1, 0);
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input string msg,
                         input logic [R-1:0] act, input logic [R-1:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, msg, act, exp);
        end
    endtask

    // monitor: pop expected result at each done
    always @(negedge clk) begin
        if (!rst && done) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R9", "done without pending request", R'(1), R'(0));
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                check(syndrome == e.syn, "R3", "syndrome", syndrome, e.syn);
                check(is_zero == e.zero, "R5", "is_zero", R'(is_zero), R'(e.zero));
            end
        end
    end

    // driver: push expectation, start, measure latency, check hold
    task automatic run_case(input logic [R-1:0] c0, input logic [R-1:0] c1,
                            input logic [R-1:0] h0, input logic [R-1:0] h1,
                            input bit disturb, input string req);
        exp_t e;
        int   c;
        e.syn  = pmul(h0, c0) ^ pmul(h1, c1);
        e.zero = (e.syn == '0);
        sb_q.push_back(e);
        @(negedge clk);
        word_in = {c1, c0};
        h0_in   = h0;
        h1_in   = h1;
        start   = 1'b1;
        c = 0;
        do begin
            @(negedge clk);
            c++;
            if (c == 1) start = 1'b0;
            if (disturb && c == 5) begin
                start   = 1'b1;            // R7: ignored while busy
                word_in = ~word_in;
                h0_in   = ~h0_in;
                h1_in   = h1_in ^ 1;
            end
            if (disturb && c == 6) start = 1'b0;
            if (c > R + exp_lat + 10) break;
        end while (!done);
        check(c == R + exp_lat + 2, req, "done latency", R'(c), R'(R + exp_lat + 2));
        check(!busy, "R2", "busy low with done", R'(busy), R'(0));
        repeat (3) @(negedge clk);
        check(!done, "R9", "done single pulse", R'(done), R'(0));
        check(syndrome == e.syn, "R8", "syndrome hold", syndrome, e.syn);
        check(is_zero == e.zero, "R8", "is_zero hold", R'(is_zero), R'(e.zero));
    endtask

    initial begin
        #(200000 * 20);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [R-1:0] h0, h1, m, c0, c1;
        int w, lv;
        // independent latency model: levels of a 6-input OR tree
        w = R; lv = 0;
        do begin w = (w + 5) / 6; lv++; end while (w > 1);
        exp_lat = (lv >= 2) ? lv - 1 : 1;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!busy && !done && !is_zero, "R1", "flags after reset",
              R'({busy, done, is_zero}), R'(0));
        check(syndrome == '0, "R1", "syndrome after reset", syndrome, R'(0));

        h0 = sparse(9);
        h1 = sparse(9);
        // R5 zero word
        run_case('0, '0, h0, h1, 0, "R5");
        // R3 single bit in low half at position 0
        run_case(R'(1), '0, h0, h1, 0, "R3");
        // R3 single bit in high half at position 5
        run_case('0, R'(1) << 5, h0, h1, 0, "R3");
        // R4 same position in both halves, different polynomials
        run_case(R'(1) << 7, R'(1) << 7, h0, h1, 0, "R4");
        // R4 identical halves with h0 == h1 cancel every step
        c0 = dense();
        run_case(c0, c0, h0, h0, 0, "R4");
        // R3 last position wraps the rotation
        run_case(R'(1) << (R - 1), R'(1) << (R - 1), h0, h1, 0, "R3");
        // R6 codeword gives zero syndrome
        m  = dense();
        run_case(pmul(h1, m), pmul(h0, m), h0, h1, 0, "R6");
        // R6 codeword with one error is nonzero
        c0 = pmul(h1, m) ^ (R'(1) << 11);
        run_case(c0, pmul(h0, m), h0, h1, 0, "R6");
        // R7 start and input changes during a run are ignored
        c0 = dense();
        c1 = dense();
        run_case(c0, c1, h0, h1, 1, "R7");
        // R3 random dense and sparse patterns
        for (int t = 0; t < 4; t++) begin
            h0 = sparse(12);
            h1 = sparse(12);
            run_case(dense(), sparse(6), h0, h1, 0, "R3");
        end
        // R6 codeword with fresh keys
        m = sparse(20);
        run_case(pmul(h1, m), pmul(h0, m), h0, h1, 0, "R6");

        repeat (5) @(negedge clk);
        check(sb_q.size() == 0, "R9", "pending results", R'(sb_q.size()), R'(0));
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule